// File: doc/BRIEF.md
# Flash Program and Block-Erase Sequencer

This block drives a byte-wide parallel flash from the system side. After one request it can program a run of consecutive bytes or erase one block. Each operation opens with the flash's two-write unlock prefix. The block then reads the target location repeatedly until the flash reports that the operation has ended. The host starts a request with a pulse on `start`, together with an operation select, a base address, a byte count and a poll limit. The bytes to program arrive on a valid/ready stream, and the block takes one byte for each address.

Bus timing is abstracted: each cycle the sequencer spends on the flash port is exactly one write or exactly one read. Read data is sampled in the same cycle as the read strobe. For program, the completion test compares the bit 7 of the read data with bit 7 of the byte just written. For erase, the expected completion value is all-ones. The flash's timing-limit flag in bit 5 is honoured with one confirming read. An optional poll-count limit catches a flash that never finishes. When a request ends, the block raises `done` for one cycle. If the request failed, it also raises `error` and reports the address that failed.

Top module: `fpe_flash_seq`

## Requirements
- R1: Each programmed byte is preceded by three writes, in this order: AAh to address 5555h, 55h to address 2AAAh and A0h to address 5555h. The data byte is then written to the target address. No other write occurs.
- R2: A block erase (`op_erase`=1) issues six writes, in this order: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 30h@`base_addr`.
- R3: After the last write of an operation, the block reads the target address every cycle until read bit 7 equals bit 7 of the expected value. The expected value is the written byte for program and FFh for erase. Program targets are `base_addr`+i for i = 0 to `byte_count`−1, and the address wraps modulo 2^AW.
- R4: If bit 7 matches but the full read byte differs from the expected value, the request ends with `error`=1 and `err_addr` set to that address. No further bus cycle is issued and no further input byte is taken.
- R5: A polling read in which bit 7 still differs and bit 5 is 1 is followed by exactly one more read. If that read equals the expected value, the operation succeeds. Otherwise the request fails at that address.
- R6: With `poll_limit`=L>0, a location that has not completed after L polling reads fails the request. When a read matches, the match takes priority over the limit. L=0 places no limit on polling.
- R7: `done` is high for exactly one cycle at the end of every request. `error` is 0 after a request that succeeded. After a failure, `error` stays at 1 until the next accepted `start`.
- R8: A `start` is accepted only while `busy`=0. `busy` stays at 1 from acceptance through the `done` cycle, and a `start` raised in that time has no effect.
- R9: A program request with `byte_count`=0 makes no bus cycle and raises `done` in the cycle after acceptance. Erase ignores `byte_count`.
- R10: `in_ready` is 1 only while the block is waiting for the next byte to program. While it waits, no bus cycle is made.
- R11: After reset, `busy`, `done`, `error`, `fl_we`, `fl_re` and `in_ready` are 0.
- R12: `fl_we` and `fl_re` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; accepted when idle |
| op_erase | input | 1 | 1 = block erase, 0 = program |
| base_addr | input | AW | First target address, or the block address |
| byte_count | input | LW | Number of bytes to program |
| poll_limit | input | PLW | Maximum number of polling reads per location; 0 = no limit |
| in_data | input | 8 | Byte to program |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Sequencer takes `in_data` this cycle |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, sampled in the read cycle |
| fl_we | output | 1 | Flash write cycle |
| fl_re | output | 1 | Flash read cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| error | output | 1 | Last request failed |
| err_addr | output | AW | Address at which the request failed |

## Verification
The bench builds the block with the default 20-bit address, a 16-bit length and a 16-bit poll limit, and with the confirming read enabled. At these widths a run can start at the all-ones address and wrap to zero. Small poll limits of 3 and 4 bring both the timeout path and the case where a read matches on the last allowed read within a few cycles. A behavioural flash model answers every read and can be set to raise the bit-5 flag, to finish on the confirming read, or to complete with a corrupted byte. The bench also checks every write against a queue of expected commands on each clock.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_CMD,
      S_POLL,
      S_RECHK,
      S_FINISH
   } seq_state_t;

   typedef enum logic [1:0] {
      V_WAIT,
      V_OK,
      V_FAIL,
      V_RECHK
   } verdict_t;

   localparam logic [14:0] KEY_ADDR_A      = 15'h5555;
   localparam logic [14:0] KEY_ADDR_B      = 15'h2AAA;
   localparam logic [7:0]  KEY_BYTE_A      = 8'hAA;
   localparam logic [7:0]  KEY_BYTE_B      = 8'h55;
   localparam logic [7:0]  OPC_PROGRAM     = 8'hA0;
   localparam logic [7:0]  OPC_ERASE_SETUP = 8'h80;
   localparam logic [7:0]  OPC_BLOCK_ERASE = 8'h30;
   localparam logic [7:0]  ERASED_BYTE     = 8'hFF;

endpackage

// File: rtl/fpe_cmd_gen.sv
module fpe_cmd_gen
   import fpe_pkg::*;
#(
   parameter int AW = 20
) (
   input  logic          op_erase,
   input  logic [2:0]    step,
   input  logic [AW-1:0] target,
   input  logic [7:0]    wbyte,
   output logic [AW-1:0] addr,
   output logic [7:0]    data,
   output logic          last
);

   localparam logic [AW-1:0] ADDR_A = AW'(KEY_ADDR_A);
   localparam logic [AW-1:0] ADDR_B = AW'(KEY_ADDR_B);

   always_comb begin
      addr = target;
      data = wbyte;
      last = 1'b0;
      if (!op_erase) begin
         case (step)
            3'd0:    begin addr = ADDR_A; data = KEY_BYTE_A;  end
            3'd1:    begin addr = ADDR_B; data = KEY_BYTE_B;  end
            3'd2:    begin addr = ADDR_A; data = OPC_PROGRAM; end
            default: begin addr = target; data = wbyte; last = 1'b1; end
         endcase
      end else begin
         case (step)
            3'd0:    begin addr = ADDR_A; data = KEY_BYTE_A;      end
            3'd1:    begin addr = ADDR_B; data = KEY_BYTE_B;      end
            3'd2:    begin addr = ADDR_A; data = OPC_ERASE_SETUP; end
            3'd3:    begin addr = ADDR_A; data = KEY_BYTE_A;      end
            3'd4:    begin addr = ADDR_B; data = KEY_BYTE_B;      end
            default: begin addr = target; data = OPC_BLOCK_ERASE; last = 1'b1; end
         endcase
      end
   end

endmodule

// File: rtl/fpe_poll_timer.sv
module fpe_poll_timer #(
   parameter int PLW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           tick,
   input  logic [PLW-1:0] limit,
   output logic           expired
);

   localparam logic [PLW-1:0] CNT_MAX = {PLW{1'b1}};

   logic [PLW-1:0] cnt;
   logic [PLW:0]   cnt_next;

   assign cnt_next = {1'b0, cnt} + {{PLW{1'b0}}, 1'b1};
   assign expired  = (|limit) && (cnt_next >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (tick && cnt != CNT_MAX) begin
         cnt <= cnt_next[PLW-1:0];
      end
   end

endmodule

// File: rtl/fpe_poll_judge.sv
module fpe_poll_judge
   import fpe_pkg::*;
#(
   parameter bit RECHECK_ON_FLAG = 1'b1
) (
   input  logic [7:0] rdata,
   input  logic [7:0] expect_byte,
   input  logic       in_recheck,
   input  logic       expired,
   output verdict_t   verdict
);

   verdict_t flag_verdict;

   generate
      if (RECHECK_ON_FLAG) begin : g_confirm
         assign flag_verdict = V_RECHK;
      end else begin : g_direct
         assign flag_verdict = V_FAIL;
      end
   endgenerate

   logic full_eq;
   logic msb_eq;
   assign full_eq = (rdata == expect_byte);
   assign msb_eq  = (rdata[7] == expect_byte[7]);

   always_comb begin
      if (in_recheck)      verdict = full_eq ? V_OK : V_FAIL;
      else if (msb_eq)     verdict = full_eq ? V_OK : V_FAIL;
      else if (rdata[5])   verdict = flag_verdict;
      else if (expired)    verdict = V_FAIL;
      else                 verdict = V_WAIT;
   end

endmodule

// File: rtl/fpe_flash_seq.sv
module fpe_flash_seq
   import fpe_pkg::*;
#(
   parameter int AW              = 20,
   parameter int LW              = 16,
   parameter int PLW             = 16,
   parameter bit RECHECK_ON_FLAG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           op_erase,
   input  logic [AW-1:0]  base_addr,
   input  logic [LW-1:0]  byte_count,
   input  logic [PLW-1:0] poll_limit,
   input  logic [7:0]     in_data,
   input  logic           in_valid,
   output logic           in_ready,
   output logic [AW-1:0]  fl_addr,
   output logic [7:0]     fl_wdata,
   input  logic [7:0]     fl_rdata,
   output logic           fl_we,
   output logic           fl_re,
   output logic           busy,
   output logic           done,
   output logic           error,
   output logic [AW-1:0]  err_addr
);

   generate
      if (AW < 15) begin : g_bad_aw
         $error("fpe_flash_seq: AW must cover the unlock addresses");
      end
      if (LW < 1 || PLW < 1) begin : g_bad_len
         $error("fpe_flash_seq: LW and PLW must be positive");
      end
   endgenerate

   localparam logic [LW-1:0] LEN_ONE  = LW'(1);
   localparam logic [AW-1:0] ADDR_ONE = AW'(1);

   seq_state_t     state;
   logic           op_r;
   logic [AW-1:0]  addr_r;
   logic [LW-1:0]  rem_r;
   logic [PLW-1:0] limit_r;
   logic [7:0]     byte_r;
   logic [2:0]     step_r;
   logic           err_r;
   logic [AW-1:0]  err_addr_r;

   logic [AW-1:0]  cmd_addr;
   logic [7:0]     cmd_data;
   logic           cmd_last;
   logic           expired;
   logic [7:0]     expect_byte;
   verdict_t       verdict;

   assign expect_byte = op_r ? ERASED_BYTE : byte_r;

   fpe_cmd_gen #(.AW(AW)) u_cmd (
      .op_erase (op_r),
      .step     (step_r),
      .target   (addr_r),
      .wbyte    (byte_r),
      .addr     (cmd_addr),
      .data     (cmd_data),
      .last     (cmd_last)
   );

   fpe_poll_timer #(.PLW(PLW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state == S_CMD),
      .tick    (state == S_POLL),
      .limit   (limit_r),
      .expired (expired)
   );

   fpe_poll_judge #(.RECHECK_ON_FLAG(RECHECK_ON_FLAG)) u_judge (
      .rdata       (fl_rdata),
      .expect_byte (expect_byte),
      .in_recheck  (state == S_RECHK),
      .expired     (expired),
      .verdict     (verdict)
   );

   assign fl_we    = (state == S_CMD);
   assign fl_re    = (state == S_POLL) || (state == S_RECHK);
   assign fl_addr  = fl_we ? cmd_addr : addr_r;
   assign fl_wdata = fl_we ? cmd_data : 8'h00;
   assign in_ready = (state == S_FETCH);
   assign busy     = (state != S_IDLE);
   assign done     = (state == S_FINISH);
   assign error    = err_r;
   assign err_addr = err_addr_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         op_r       <= 1'b0;
         addr_r     <= '0;
         rem_r      <= '0;
         limit_r    <= '0;
         byte_r     <= '0;
         step_r     <= '0;
         err_r      <= 1'b0;
         err_addr_r <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (start) begin
                  op_r    <= op_erase;
                  addr_r  <= base_addr;
                  rem_r   <= byte_count;
                  limit_r <= poll_limit;
                  byte_r  <= ERASED_BYTE;
                  step_r  <= '0;
                  err_r   <= 1'b0;
                  if (op_erase)             state <= S_CMD;
                  else if (byte_count == '0) state <= S_FINISH;
                  else                      state <= S_FETCH;
               end
            end
            S_FETCH: begin
               if (in_valid) begin
                  byte_r <= in_data;
                  step_r <= '0;
                  state  <= S_CMD;
               end
            end
            S_CMD: begin
               if (cmd_last) state <= S_POLL;
               else          step_r <= step_r + 3'd1;
            end
            S_POLL, S_RECHK: begin
               case (verdict)
                  V_OK: begin
                     if (!op_r && rem_r > LEN_ONE) begin
                        addr_r <= addr_r + ADDR_ONE;
                        rem_r  <= rem_r - LEN_ONE;
                        state  <= S_FETCH;
                     end else begin
                        state <= S_FINISH;
                     end
                  end
                  V_FAIL: begin
                     err_r      <= 1'b1;
                     err_addr_r <= addr_r;
                     state      <= S_FINISH;
                  end
                  V_RECHK: state <= S_RECHK;
                  default: state <= state;
               endcase
            end
            S_FINISH: state <= S_IDLE;
            default:  state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fpe_flash_seq_chk.sv
module fpe_flash_seq_chk #(
   parameter int AW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          error,
   input logic [AW-1:0] err_addr,
   input logic          fl_we,
   input logic          fl_re,
   input logic          in_ready
);

   AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re)); // R12

   AST_BUS_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we || fl_re) |-> (busy && !done)); // R1

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy); // R8

   AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R8

   AST_READY_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!fl_we && !fl_re)); // R10

   AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !(start && !busy)) |=> error); // R7

   AST_ERR_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !(start && !busy)) |=> $stable(err_addr)); // R4

endmodule

bind fpe_flash_seq fpe_flash_seq_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .error    (error),
   .err_addr (err_addr),
   .fl_we    (fl_we),
   .fl_re    (fl_re),
   .in_ready (in_ready)
);

// File: tb/fpe_flash_seq_tb.sv
`timescale 1ns/1ps
module fpe_flash_seq_tb;

   localparam int AW  = 20;
   localparam int LW  = 16;
   localparam int PLW = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           op_erase = 1'b0;
   logic [AW-1:0]  base_addr = '0;
   logic [LW-1:0]  byte_count = '0;
   logic [PLW-1:0] poll_limit = '0;
   logic [7:0]     in_data = '0;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic [AW-1:0]  fl_addr;
   logic [7:0]     fl_wdata;
   logic [7:0]     fl_rdata;
   logic           fl_we;
   logic           fl_re;
   logic           busy;
   logic           done;
   logic           error;
   logic [AW-1:0]  err_addr;

   always #2.5 clk = ~clk;

   fpe_flash_seq #(.AW(AW), .LW(LW), .PLW(PLW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
      .base_addr(base_addr), .byte_count(byte_count), .poll_limit(poll_limit),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
      .fl_we(fl_we), .fl_re(fl_re), .busy(busy), .done(done),
      .error(error), .err_addr(err_addr)
   );

   typedef struct {
      logic [AW-1:0] a;
      logic [7:0]    d;
      bit            last;
      logic [7:0]    val;
   } wr_t;

   wr_t        exp_q[$];
   logic [7:0] src_q[$];

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int n_reads = 0;
   int n_bytes = 0;
   int done_cnt = 0;
   bit done_prev = 1'b0;
   bit stall_en = 1'b0;
   string tag = "R1";

   // flash model controls and state
   int            busy_reads = 0;
   int            bit5_at = 1000000;
   bit            corrupt_en = 1'b0;
   logic [AW-1:0] corrupt_addr = '0;
   int            rd_cnt = 0;
   logic [7:0]    cval = 8'hFF;
   logic [AW-1:0] m_tgt = '0;

   always @* begin
      if (rd_cnt < busy_reads)
         fl_rdata = {~cval[7], rd_cnt[0], (rd_cnt + 1 >= bit5_at), 5'b00000};
      else
         fl_rdata = cval;
   end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic chk(bit ok, string req, string what, longint act, longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // flash model state advances with non-blocking updates at the edge
   always @(posedge clk) begin
      if (fl_we && exp_q.size() > 0) begin
         if (exp_q[0].last) begin
            rd_cnt <= 0;
            m_tgt  <= exp_q[0].a;
            cval   <= (corrupt_en && exp_q[0].a == corrupt_addr) ?
                      (exp_q[0].val ^ 8'h01) : exp_q[0].val;
         end
         void'(exp_q.pop_front());
      end
      if (fl_re) begin
         rd_cnt <= rd_cnt + 1;
         n_reads++;
      end
      if (in_valid && in_ready && src_q.size() > 0) begin
         void'(src_q.pop_front());
         n_bytes++;
      end
   end

   // reference comparison on every clock, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         summary();
         $finish;
      end
      if (fl_we) begin
         if (exp_q.size() == 0)
            chk(1'b0, tag, "unexpected write", longint'(fl_addr), 0);
         else
            chk(fl_addr == exp_q[0].a && fl_wdata == exp_q[0].d, tag,
                "write addr/data", {fl_addr, fl_wdata}, {exp_q[0].a, exp_q[0].d});
      end
      if (fl_re)
         chk(fl_addr == m_tgt, "R3", "poll address", longint'(fl_addr), longint'(m_tgt));
      if (fl_we && fl_re)
         chk(1'b0, "R12", "write and read together", 1, 0);
      if (done && done_prev)
         chk(1'b0, "R7", "done longer than one cycle", 1, 0);
      if (done) done_cnt++;
      done_prev = done;
      in_valid = (src_q.size() > 0) && !(stall_en && (cyc % 3 == 1));
      in_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
   end

   task automatic push_prog(logic [AW-1:0] a, logic [7:0] d);
      exp_q.push_back('{a: AW'(20'h05555), d: 8'hAA, last: 1'b0, val: 8'h00});
      exp_q.push_back('{a: AW'(20'h02AAA), d: 8'h55, last: 1'b0, val: 8'h00});
      exp_q.push_back('{a: AW'(20'h05555), d: 8'hA0, last: 1'b0, val: 8'h00});
      exp_q.push_back('{a: a, d: d, last: 1'b1, val: d});
   endtask

   task automatic push_erase(logic [AW-1:0] a);
      exp_q.push_back('{a: AW'(20'h05555), d: 8'hAA, last: 1'b0, val: 8'h00});
      exp_q.push_back('{a: AW'(20'h02AAA), d: 8'h55, last: 1'b0, val: 8'h00});
      exp_q.push_back('{a: AW'(20'h05555), d: 8'h80, last: 1'b0, val: 8'h00});
      exp_q.push_back('{a: AW'(20'h05555), d: 8'hAA, last: 1'b0, val: 8'h00});
      exp_q.push_back('{a: AW'(20'h02AAA), d: 8'h55, last: 1'b0, val: 8'h00});
      exp_q.push_back('{a: a, d: 8'h30, last: 1'b1, val: 8'hFF});
   endtask

   task automatic run_req(bit er, logic [AW-1:0] base, int len, int limit,
                          bit poke, string req, bit exp_err,
                          logic [AW-1:0] exp_ea, int exp_reads, int exp_bytes,
                          int exp_lat);
      int lat;
      n_reads = 0;
      n_bytes = 0;
      done_cnt = 0;
      tag = req;
      @(negedge clk);
      start = 1'b1; op_erase = er; base_addr = base;
      byte_count = LW'(len); poll_limit = PLW'(limit);
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         start = 1'b1; op_erase = ~er; base_addr = AW'(20'h70000);
         @(negedge clk);
         start = 1'b0;
      end
      lat = 0;
      while (!done) begin
         @(negedge clk);
         lat++;
      end
      chk(error == exp_err, req, "error at done", error, exp_err);
      if (exp_err)
         chk(err_addr == exp_ea, "R4", "err_addr", err_addr, exp_ea);
      if (exp_lat >= 0)
         chk(lat == exp_lat, req, "cycles to done", lat, exp_lat);
      @(negedge clk);
      chk(!done && !busy, "R7", "done/busy after end", {done, busy}, 0);
      chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
      chk(n_reads == exp_reads, req, "polling reads", n_reads, exp_reads);
      chk(n_bytes == exp_bytes, "R10", "bytes taken", n_bytes, exp_bytes);
      chk(exp_q.size() == 0, req, "writes left unissued", exp_q.size(), 0);
      exp_q.delete();
      src_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, error, fl_we, fl_re, in_ready} == 6'b0, "R11",
          "reset outputs", {busy, done, error, fl_we, fl_re, in_ready}, 0);

      // R1 R3 R8 R10: four bytes, stalled stream, ignored start while busy
      busy_reads = 2; bit5_at = 1000000; corrupt_en = 1'b0; stall_en = 1'b1;
      src_q = '{8'h3C, 8'hA5, 8'h00, 8'hFF};
      push_prog(20'h01230, 8'h3C); push_prog(20'h01231, 8'hA5);
      push_prog(20'h01232, 8'h00); push_prog(20'h01233, 8'hFF);
      run_req(1'b0, 20'h01230, 4, 0, 1'b1, "R1", 1'b0, '0, 12, 4, -1);
      stall_en = 1'b0;

      // R2 R9: block erase, length ignored
      busy_reads = 5;
      push_erase(20'h40000);
      run_req(1'b1, 20'h40000, 5, 0, 1'b0, "R2", 1'b0, '0, 6, 0, -1);

      // R9: zero-length program
      run_req(1'b0, 20'h00100, 0, 0, 1'b0, "R9", 1'b0, '0, 0, 0, 0);

      // R6: timeout after four reads
      busy_reads = 1000000;
      src_q = '{8'h5A};
      push_prog(20'h00200, 8'h5A);
      run_req(1'b0, 20'h00200, 1, 4, 1'b0, "R6", 1'b1, 20'h00200, 4, 1, -1);
      repeat (3) @(negedge clk);
      chk(error == 1'b1, "R7", "error held after failure", error, 1);

      // R6: completion on the last allowed read wins over the limit
      busy_reads = 2;
      src_q = '{8'h81};
      push_prog(20'h00300, 8'h81);
      run_req(1'b0, 20'h00300, 1, 3, 1'b0, "R6", 1'b0, '0, 3, 1, -1);

      // R5: bit 5 flag, confirming read still busy -> fail
      busy_reads = 1000000; bit5_at = 2;
      src_q = '{8'h12};
      push_prog(20'h00400, 8'h12);
      run_req(1'b0, 20'h00400, 1, 0, 1'b0, "R5", 1'b1, 20'h00400, 3, 1, -1);

      // R5 R7: bit 5 flag, operation finishes on the confirming read
      busy_reads = 2; bit5_at = 2;
      src_q = '{8'h34};
      push_prog(20'h00500, 8'h34);
      run_req(1'b0, 20'h00500, 1, 0, 1'b0, "R5", 1'b0, '0, 3, 1, -1);
      bit5_at = 1000000;

      // R4: corrupted second byte of three
      busy_reads = 1; corrupt_en = 1'b1; corrupt_addr = 20'h00601;
      src_q = '{8'h11, 8'h22, 8'h33};
      push_prog(20'h00600, 8'h11); push_prog(20'h00601, 8'h22);
      run_req(1'b0, 20'h00600, 3, 0, 1'b0, "R4", 1'b1, 20'h00601, 4, 2, -1);

      // R4: erase completes with a non-erased byte
      corrupt_addr = 20'h50000;
      push_erase(20'h50000);
      run_req(1'b1, 20'h50000, 0, 0, 1'b0, "R4", 1'b1, 20'h50000, 2, 0, -1);
      corrupt_en = 1'b0;

      // R3: address wraps at the top
      busy_reads = 0;
      src_q = '{8'hC3, 8'h7E};
      push_prog(20'hFFFFF, 8'hC3); push_prog(20'h00000, 8'h7E);
      run_req(1'b0, 20'hFFFFF, 2, 0, 1'b0, "R3", 1'b0, '0, 2, 2, -1);

      summary();
      $finish;
   end

endmodule